// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter with Line Break

This block turns bytes into asynchronous serial frames on a single output line. A byte arrives over a ready/valid handshake. The block wraps it in a start bit, the data bits, an optional parity bit and one or two stop bits, then shifts the frame out least significant data bit first. Bit timing comes from a tick input that pulses at sixteen times the bit rate. A six-bit line-control word sets the frame shape. The block captures this word when each frame begins.

Two line-management functions sit beside the data path. A one-cycle break request makes the block send an all-zero frame once the frame in progress has finished. The frame has the length of the current format, and a status output stays high until that frame is complete. When flow gating is enabled, the block starts no new data frame until the active-low clear-to-send input is asserted. A frame that is already on the line always runs to its end.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. `tx_empty` is 1 exactly when no frame is in progress, no break is pending and `in_valid` is low.
- R2: Each data frame starts with a single 0 bit. The data bits follow, least significant first. Their count is set by `lcr_word[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: `lcr_word[4:2]` selects the parity bit sent right after the data. 0xx sends no parity bit, 100 sends odd parity, 101 sends even parity, 110 sends a constant 1 and 111 sends a constant 0.
- R4: `lcr_word[5]` = 0 ends a frame with one stop bit and 1 ends it with two. Stop bits are 1.
- R5: Every bit of a frame holds for exactly 16 pulses of `tick16`, whatever the spacing of those pulses in clock cycles.
- R6: The block captures `lcr_word` in the cycle a frame starts. Changes made later have no effect on that frame.
- R7: A one-cycle `brk_req` sets `brk_busy`. If a frame is in progress, it completes unchanged. The block then sends a frame of all 0 bits, as long as a frame in the current format, and clears `brk_busy` at its end. A pending break goes ahead of a waiting byte and ignores clear-to-send. Normal frames follow afterwards.
- R8: With `afc_en` = 1 and `cts_n` = 1, no data frame starts, `in_ready` is 0 and `txd` stays 1. With `afc_en` = 0, `cts_n` has no effect.
- R9: A byte is taken on a clock edge where both `in_valid` and `in_ready` are 1, and its frame starts in that same cycle. `in_ready` is 1 only when no frame is in progress, no break is pending and clear-to-send permits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Strobe at sixteen times the bit rate |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block takes the byte this cycle |
| lcr_word | input | 6 | Frame format: [1:0] data length, [4:2] parity, [5] two stop bits |
| brk_req | input | 1 | One-cycle request to send a break |
| brk_busy | output | 1 | Break pending or being sent; clears itself |
| cts_n | input | 1 | Clear-to-send, active low |
| afc_en | input | 1 | Enables clear-to-send gating |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Nothing in progress and nothing pending |

## Verification
The embedded properties hold on every cycle for these line-level invariants:
- the line is high whenever the block reports empty;
- a frame always opens with a low bit;
- the last bit of a data frame is high;
- a break frame is low throughout;
- a pending break survives the data frame ahead of it;
- a blocked clear-to-send prevents any start;
- an accepted byte starts a data frame.

Only the bench scenarios can show the following:
- the exact bit pattern of each format, including the parity variants and stop counts;
- the sixteen-tick bit length under uneven tick spacing;
- that the format is captured once per frame;
- that a break comes ahead of a waiting byte and lasts exactly one frame in the current format.

The bench records the line once per tick and compares every sample with frames it builds itself.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_MAX  = 8;
  localparam int LCR_W     = 6;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic { FK_DATA = 1'b0, FK_BREAK = 1'b1 } frame_kind_t;

  // number of data bits for a length code
  function automatic int data_len(input logic [1:0] code);
    return 5 + int'(code);
  endfunction

  // parity bit value for the data under the selected parity code
  function automatic logic parity_of(input logic [DATA_MAX-1:0] d,
                                     input logic [LCR_W-1:0] lcr);
    logic [DATA_MAX-1:0] m;
    int n;
    n = data_len(lcr[1:0]);
    m = '0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < n) m[i] = d[i];
    case (lcr[3:2])
      2'b00:   return ~(^m);
      2'b01:   return ^m;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // total bit count of a frame
  function automatic logic [LEN_W-1:0] frame_len(input logic [LCR_W-1:0] lcr);
    int n;
    n = 2 + data_len(lcr[1:0]) + int'(lcr[4]) + int'(lcr[5]);
    return LEN_W'(n);
  endfunction

  // frame bits in send order, bit 0 first; unused tail stays high
  function automatic logic [FRAME_MAX-1:0] frame_vec(input logic [DATA_MAX-1:0] d,
                                                     input logic [LCR_W-1:0] lcr);
    logic [FRAME_MAX-1:0] v;
    int n;
    n = data_len(lcr[1:0]);
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < n) v[1+i] = d[i];
    if (lcr[4]) v[1+n] = parity_of(d, lcr);
    return v;
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] CMAX = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart)           cnt <= '0;
    else if (run && tick)       cnt <= (cnt == CMAX) ? '0 : cnt + 1'b1;
  end

  assign bit_end = run && tick && (cnt == CMAX);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] load_vec,
  input  logic [LEN_W-1:0]     load_len,
  input  logic                 advance,
  output logic                 busy,
  output logic                 last,
  output logic                 line
);
  logic [FRAME_MAX-1:0] sr;
  logic [LEN_W-1:0]     left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
    end else if (load) begin
      sr   <= load_vec;
      left <= load_len;
    end else if (advance && left != '0) begin
      sr   <= {1'b1, sr[FRAME_MAX-1:1]};
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
  assign last = (left == LEN_W'(1));
  assign line = busy ? sr[0] : 1'b1;

  // R9: the controller loads only while the shifter is empty
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> left == '0);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic [DATA_MAX-1:0]  in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LCR_W-1:0]     lcr_word,
  input  logic                 brk_req,
  output logic                 brk_busy,
  input  logic                 cts_n,
  input  logic                 afc_en,
  output logic                 txd,
  output logic                 tx_empty
);
  logic busy, last, bit_end;
  logic cts_ok, start_data, start_brk, load, frame_end;
  logic [FRAME_MAX-1:0] load_vec;
  logic [LEN_W-1:0]     load_len;
  frame_kind_t          cur_kind;

  assign cts_ok     = !afc_en || !cts_n;
  assign in_ready   = !busy && !brk_busy && cts_ok;
  assign start_brk  = !busy && brk_busy;
  assign start_data = in_valid && in_ready;
  assign load       = start_brk || start_data;
  assign frame_end  = busy && bit_end && last;
  assign load_len   = frame_len(lcr_word);
  assign load_vec   = start_brk ? '0 : frame_vec(in_data, lcr_word);
  assign tx_empty   = !busy && !brk_busy && !in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind <= FK_DATA;
      brk_busy <= 1'b0;
    end else begin
      if (load) cur_kind <= start_brk ? FK_BREAK : FK_DATA;
      if (brk_req) brk_busy <= 1'b1;
      else if (frame_end && cur_kind == FK_BREAK) brk_busy <= 1'b0;
    end
  end

  uart_tx_baud #(.OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(load), .run(busy),
    .tick(tick16), .bit_end(bit_end)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_vec(load_vec),
    .load_len(load_len), .advance(bit_end), .busy(busy),
    .last(last), .line(txd)
  );

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
  p_start_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_last_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && cur_kind == FK_DATA) |-> txd);
  p_brk_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_kind == FK_BREAK) |-> !txd);
  p_brk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_busy && busy && cur_kind == FK_DATA) |=> brk_busy);
  p_cts_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (afc_en && cts_n && !busy && !brk_busy) |=> !busy);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && cur_kind == FK_DATA));
endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  logic clk = 0, rst_n = 0, tick16 = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, brk_req = 0, cts_n = 1, afc_en = 0;
  logic [5:0] lcr_word = 6'b000011;
  logic in_ready, brk_busy, txd, tx_empty;

  int tests = 0, fails = 0;
  int tick_div = 1, tdiv_cnt = 0;

  // expected frame queue
  logic [11:0] q_bits [0:255];
  int          q_len  [0:255];
  logic        q_brk  [0:255];
  int wr = 0, rd = 0;

  // monitor state
  bit in_frame = 0;
  int pos = 0;
  logic [11:0] cur_bits, obs_bits;
  int cur_len;
  bit cur_brk, cur_err;

  always #10 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .lcr_word(lcr_word),
    .brk_req(brk_req), .brk_busy(brk_busy), .cts_n(cts_n),
    .afc_en(afc_en), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // build an expected frame from the requirement text
  function automatic void build(input logic [7:0] d, input logic [5:0] lc, input bit brk,
                                output logic [11:0] b, output int n);
    int nd, ones;
    logic p;
    nd = 5 + int'(lc[1:0]);
    b = '1;
    b[0] = 1'b0;
    n = 1;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      b[n] = d[i];
      if (d[i]) ones++;
      n++;
    end
    if (lc[4]) begin
      case (lc[3:2])
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      b[n] = p;
      n++;
    end
    n = n + 1 + int'(lc[5]);
    if (brk) b = '0;
  endfunction

  function automatic void push(input logic [7:0] d, input logic [5:0] lc, input bit brk);
    logic [11:0] b;
    int n;
    build(d, lc, brk, b, n);
    q_bits[wr[7:0]] = b;
    q_len[wr[7:0]]  = n;
    q_brk[wr[7:0]]  = brk;
    wr++;
  endfunction

  // tick generator (R5: uneven spacing when tick_div > 1)
  always @(posedge clk) begin
    #1;
    if (tdiv_cnt >= tick_div - 1) begin tick16 = 1; tdiv_cnt = 0; end
    else begin tick16 = 0; tdiv_cnt++; end
  end

  // line monitor: one sample per tick, compared bit by bit
  always @(negedge clk) begin
    if (rst_n && tick16) begin
      if (!in_frame && txd == 1'b0) begin
        in_frame = 1;
        pos = 0;
        cur_err = 0;
        obs_bits = '1;
        if (rd == wr) begin
          check(0, "R9 unexpected frame", 0, 1);
          cur_bits = '0; cur_len = 12; cur_brk = 0;
        end else begin
          cur_bits = q_bits[rd[7:0]]; cur_len = q_len[rd[7:0]];
          cur_brk = q_brk[rd[7:0]]; rd++;
        end
      end
      if (in_frame) begin
        if (txd !== cur_bits[pos/16]) cur_err = 1;
        if (pos % 16 == 8) obs_bits[pos/16] = txd;
        pos++;
        if (pos == cur_len * 16) begin
          in_frame = 0;
          // R2 R3 R4 R5 R6 for data frames, R7 for break frames
          if (cur_brk) check(!cur_err, "R7 break frame", int'(obs_bits), int'(cur_bits));
          else check(!cur_err, "R2 R3 R4 R5 R6 data frame", int'(obs_bits), int'(cur_bits));
        end
      end
    end
  end

  task automatic send(input logic [7:0] d);
    @(posedge clk); #1;
    in_data = d; in_valid = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    push(d, lcr_word, 0);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic request_break();
    @(posedge clk); #1;
    brk_req = 1;
    push(8'h00, lcr_word, 1);
    @(posedge clk); #1;
    brk_req = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && !in_frame));
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 R9 reset state
    check(txd == 1, "R1 reset txd", txd, 1);
    check(tx_empty == 1, "R1 reset tx_empty", tx_empty, 1);
    check(brk_busy == 0, "R7 reset brk_busy", brk_busy, 0);
    check(in_ready == 1, "R9 reset in_ready", in_ready, 1);

    // directed sweep of every format code
    for (int c = 0; c < 64; c++) begin
      lcr_word = c[5:0];
      send(8'hA5 ^ c[7:0]);
      @(negedge clk);
      if (c == 0) check(tx_empty == 0, "R1 busy tx_empty", tx_empty, 0);
      wait_idle();
    end

    // random traffic, uneven ticks, format changed mid-frame (R6)
    for (int k = 0; k < 30; k++) begin
      tick_div = 1 + int'($urandom_range(2));
      lcr_word = 6'($urandom);
      send(8'($urandom));
      wait_cycles(5 + int'($urandom_range(90)));
      lcr_word = 6'($urandom);
      wait_idle();
    end
    tick_div = 1;

    // R8 gating: blocked while cts_n high
    lcr_word = 6'b010011;
    afc_en = 1; cts_n = 1;
    @(posedge clk); #1;
    in_data = 8'h3C; in_valid = 1;
    ok = 1;
    repeat (300) begin
      @(negedge clk);
      if (txd != 1 || in_ready != 0 || brk_busy != 0) ok = 0;
    end
    check(ok, "R8 cts hold", txd, 1);
    check(tx_empty == 0, "R1 byte pending", tx_empty, 0);
    @(posedge clk); #1 cts_n = 0;
    forever begin @(negedge clk); if (in_ready) break; end
    push(8'h3C, lcr_word, 0);
    @(posedge clk); #1 in_valid = 0;
    wait_cycles(40);
    cts_n = 1;            // frame in progress completes anyway
    wait_idle();
    check(rd == wr, "R8 frame after cts", rd, wr);
    afc_en = 0;           // gating off: cts_n ignored
    send(8'hC3);
    wait_idle();
    check(rd == wr, "R8 afc off ignores cts", rd, wr);
    cts_n = 0;

    // R7 break waits for the current frame, then clears itself
    lcr_word = 6'b100011;
    send(8'h81);
    wait_cycles(20);
    request_break();
    @(negedge clk);
    check(brk_busy == 1, "R7 status set", brk_busy, 1);
    check(in_ready == 0, "R9 ready low while break pending", in_ready, 0);
    do @(negedge clk); while (brk_busy);
    check(txd == 1 && tx_empty == 1, "R7 line released after break", txd, 1);
    check(rd == wr, "R7 break frame seen", rd, wr);
    send(8'h5A);
    wait_idle();
    check(rd == wr, "R7 normal after break", rd, wr);

    // R7 priority over a waiting byte, and break ignores cts
    lcr_word = 6'b001110;
    send(8'h0F);
    wait_cycles(10);
    request_break();
    afc_en = 1; cts_n = 1;
    wait_cycles(400);
    check(brk_busy == 0, "R7 break ignores cts", brk_busy, 0);
    cts_n = 0;
    send(8'hF0);
    wait_idle();
    afc_en = 0;
    lcr_word = 6'b000001;
    send(8'h11);
    wait_cycles(10);
    request_break();
    send(8'h22);          // queued behind the break
    wait_idle();
    check(rd == wr, "R7 break before waiting byte", rd, wr);

    wait_cycles(50);
    check(in_frame == 0 && rd == wr, "R1 quiet at end", rd, wr);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule